// File: doc/BRIEF.md
# Real-Time Clock Host Register File

This block is the host side of a real-time clock. A processor reaches it through an 8-bit bus with two addresses. A write to the even address selects one of 128 byte registers, and the odd address then reads or writes the selected byte. Most bytes are plain storage: time-of-day, alarm and scratch bytes. Four bytes are control and status registers with their own rules:

- A holds the rate and divider bits plus a read-only update-in-progress bit.
- B holds the set (hold) bit, the interrupt enables and the format bits.
- C holds the event flags and is cleared when it is read.
- D is a constant.

The calendar counter and the periodic-rate divider are separate blocks. They report events on single-cycle flag-set inputs. The calendar writes re-rendered time bytes back through its own write port and reads bytes through its own read port. This block signals the calendar with registered strobes. One strobe tells it to load its count from the time bytes. The other tells it to re-render those bytes after a format change. A level output tells the calendar to inhibit updates while the host holds set mode. The interrupt line is the registered summary flag of the status byte.

Top module: `rtc_host_regs`

## Requirements
- R1: A write to the even address stores bits 6:0 of the write data as the current index. A read of the even address returns 0xFF.
- R2: At the odd address, the host reads and writes the storage byte selected by the index. This covers every index outside 10..13. A calendar write to a storage index updates that byte, unless the host writes the same byte in the same cycle. The calendar read port returns the same bytes the host would read.
- R3: Host writes to index 12 (C) and index 13 (D) change nothing. Index 13 always reads 0x80.
- R4: A host write to index 10 (A) replaces bits 6:0 and leaves bit 7 (update in progress) as it was. The update-start input sets bit 7 only while B bit 7 is 0. The update-end flag input clears bit 7.
- R5: A host write to index 11 (B) with bit 7 set stores the value with bit 4 forced to 0 and clears A bit 7. The hold output follows B bit 7.
- R6: The load strobe is high for the one cycle after either of two writes. The first is a B write with bit 7 clear while B bit 7 was set. The second is a write to a time index (0, 2, 4, 6, 7, 8 or 9) while B bit 7 is 0. It stays low for writes to other indices and while B bit 7 is set.
- R7: The render strobe is high for the one cycle after a B write that has bit 7 clear and changes bit 2 (binary) or bit 1 (24-hour).
- R8: The three flag-set inputs set C bits 6 (periodic), 5 (alarm) and 4 (update end). C bit 7 is set when an event arrives whose enable is set: B bit 6, B bit 5 or B bit 4 respectively. The interrupt output equals C bit 7.
- R9: A host read of index 12 returns C as it stood before the read, then clears C. The interrupt output is low in the following cycle.
- R10: A flag-set input that arrives in the same cycle as a read of C is not lost. It appears in C one cycle after the clear.
- R11: After the reset input, A=0x26, B=0x02, C=0x00, D=0x80, the index is 0 and the interrupt output is low.
- R12: The soft-clear input clears B bits 6, 5 and 3, clears all of C and any held flag, and lowers the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr_i | input | 1 | Clears the enables and flags named in R12 |
| bus_cs_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = index port, 1 = data port |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data, valid in the access cycle |
| per_set_i | input | 1 | Periodic event pulse |
| alm_set_i | input | 1 | Alarm match pulse |
| upd_set_i | input | 1 | Update-ended pulse |
| uip_set_i | input | 1 | Update-started pulse |
| cal_wr_i | input | 1 | Calendar write-back enable |
| cal_idx_i | input | 7 | Calendar write-back index |
| cal_data_i | input | 8 | Calendar write-back data |
| cal_rd_idx_i | input | 7 | Calendar read index |
| cal_rd_data_o | output | 8 | Calendar read data |
| cal_load_o | output | 1 | Strobe: load the count from the time bytes |
| cal_render_o | output | 1 | Strobe: re-render the time bytes in the new format |
| hold_o | output | 1 | Set mode active, updates inhibited |
| bin_mode_o | output | 1 | Binary (1) or BCD (0) time bytes |
| h24_o | output | 1 | 24-hour (1) or 12-hour (0) time bytes |
| irq_o | output | 1 | Level interrupt |

## Verification
The hazard is a flag-set pulse that lands in the same cycle as the host read that clears the status byte. The random phase drives all three flag inputs independently, so that collision happens many times. A directed sequence also reads C while the periodic flag fires. The read must return the old value and the interrupt must go low. One cycle later the held flag must appear in C. The next read must then return 0xC0, because the periodic enable is on. A second collision is a calendar write-back and a host write to the same byte in the same cycle. The bench model expects the host data to win.

// File: rtl/rtc_host_pkg.sv
package rtc_host_pkg;

  localparam int unsigned REG_W = 8;

  localparam int unsigned IDX_A = 10;
  localparam int unsigned IDX_B = 11;
  localparam int unsigned IDX_C = 12;
  localparam int unsigned IDX_D = 13;

  localparam logic [REG_W-1:0] RST_A     = 8'h26;
  localparam logic [REG_W-1:0] RST_B     = 8'h02;
  localparam logic [REG_W-1:0] FIXED_D   = 8'h80;
  localparam logic [REG_W-1:0] IDX_RDVAL = 8'hFF;

  // control byte B
  localparam int unsigned B_HOLD = 7;
  localparam int unsigned B_PEN  = 6;
  localparam int unsigned B_AEN  = 5;
  localparam int unsigned B_UEN  = 4;
  localparam int unsigned B_SQW  = 3;
  localparam int unsigned B_BIN  = 2;
  localparam int unsigned B_H24  = 1;

  // status byte C
  localparam int unsigned C_SUM = 7;
  localparam int unsigned C_PER = 6;
  localparam int unsigned C_ALM = 5;
  localparam int unsigned C_UPD = 4;

  // control byte A
  localparam int unsigned A_UIP = 7;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;

  function automatic logic is_time_idx(input int unsigned i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 6) ||
           (i == 7) || (i == 8) || (i == 9);
  endfunction

  function automatic logic is_ctl_idx(input int unsigned i);
    return (i >= IDX_A) && (i <= IDX_D);
  endfunction

endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] d_i,
  output logic [IDX_W-1:0] q_o
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (ld_i) idx_q <= d_i;
  end

  assign q_o = idx_q;

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwe_i,
  input  logic [IDX_W-1:0] hidx_i,
  input  logic [W-1:0]     hdat_i,
  input  logic             awe_i,
  input  logic [IDX_W-1:0] aidx_i,
  input  logic [W-1:0]     adat_i,
  input  logic [IDX_W-1:0] ra0_i,
  output logic [W-1:0]     rd0_o,
  input  logic [IDX_W-1:0] ra1_i,
  output logic [W-1:0]     rd1_o
);

  logic [W-1:0] flat [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic         hsel;
    logic         asel;
    logic         en;
    logic [W-1:0] nxt;
    logic [W-1:0] byte_q;

    assign hsel = hwe_i && (hidx_i == IDX_W'(g));
    assign asel = awe_i && (aidx_i == IDX_W'(g));
    assign en   = hsel || asel;
    assign nxt  = hsel ? hdat_i : adat_i;   // host port has priority

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= '0;
      else if (en) byte_q <= nxt;
    end

    assign flat[g] = byte_q;
  end

  assign rd0_o = flat[ra0_i];
  assign rd1_o = flat[ra1_i];

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr_i,
  input  logic             wr_a_i,
  input  logic             wr_b_i,
  input  logic             wr_time_i,
  input  logic             rd_c_i,
  input  logic [REG_W-1:0] wdata_i,
  input  evt_t             evt_i,
  input  logic             uip_set_i,
  output logic [REG_W-1:0] reg_a_o,
  output logic [REG_W-1:0] reg_b_o,
  output logic [REG_W-1:0] reg_c_o,
  output logic             cal_load_o,
  output logic             cal_render_o,
  output logic             irq_o
);

  logic [REG_W-1:0] a_q, a_d, b_q, b_d, c_q, c_d;
  evt_t             pend_q, pend_d, evt_all;
  logic             load_q, load_d, rend_q, rend_d;

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    c_d     = c_q;
    pend_d  = '0;
    load_d  = 1'b0;
    rend_d  = 1'b0;
    evt_all = evt_i | pend_q;

    if (wr_a_i) a_d[A_UIP-1:0] = wdata_i[A_UIP-1:0];
    if (uip_set_i && !b_q[B_HOLD]) a_d[A_UIP] = 1'b1;
    if (evt_i.upd || (wr_b_i && wdata_i[B_HOLD])) a_d[A_UIP] = 1'b0;

    if (wr_b_i) begin
      b_d = wdata_i;
      if (wdata_i[B_HOLD]) b_d[B_UEN] = 1'b0;
      load_d = !wdata_i[B_HOLD] && b_q[B_HOLD];
      rend_d = !wdata_i[B_HOLD] &&
               (wdata_i[B_BIN:B_H24] != b_q[B_BIN:B_H24]);
    end
    if (wr_time_i && !b_q[B_HOLD]) load_d = 1'b1;

    if (soft_clr_i) begin
      b_d[B_PEN] = 1'b0;
      b_d[B_AEN] = 1'b0;
      b_d[B_SQW] = 1'b0;
      c_d        = '0;
    end else if (rd_c_i) begin
      c_d    = '0;
      pend_d = evt_all;           // events of the clearing cycle wait one cycle
    end else begin
      if (evt_all.per) c_d[C_PER] = 1'b1;
      if (evt_all.alm) c_d[C_ALM] = 1'b1;
      if (evt_all.upd) c_d[C_UPD] = 1'b1;
      if ((evt_all.per && b_q[B_PEN]) || (evt_all.alm && b_q[B_AEN]) ||
          (evt_all.upd && b_q[B_UEN]))
        c_d[C_SUM] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= RST_A;
      b_q    <= RST_B;
      c_q    <= '0;
      pend_q <= '0;
      load_q <= 1'b0;
      rend_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      c_q    <= c_d;
      pend_q <= pend_d;
      load_q <= load_d;
      rend_q <= rend_d;
    end
  end

  assign reg_a_o      = a_q;
  assign reg_b_o      = b_q;
  assign reg_c_o      = c_q;
  assign cal_load_o   = load_q;
  assign cal_render_o = rend_q;
  assign irq_o        = c_q[C_SUM];

endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_host_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr_i,
  input  logic             bus_cs_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o,
  input  logic             per_set_i,
  input  logic             alm_set_i,
  input  logic             upd_set_i,
  input  logic             uip_set_i,
  input  logic             cal_wr_i,
  input  logic [IDX_W-1:0] cal_idx_i,
  input  logic [7:0]       cal_data_i,
  input  logic [IDX_W-1:0] cal_rd_idx_i,
  output logic [7:0]       cal_rd_data_o,
  output logic             cal_load_o,
  output logic             cal_render_o,
  output logic             hold_o,
  output logic             bin_mode_o,
  output logic             h24_o,
  output logic             irq_o
);

  logic [IDX_W-1:0] idx_q;
  logic             host_wr, host_rd, idx_ld, dat_wr;
  logic             cur_ctl, cur_time, cal_ctl;
  logic             st_hwe, st_awe, wr_a, wr_b, wr_time, rd_c;
  logic [REG_W-1:0] st_rd0, st_rd1, ctl_a, ctl_b, ctl_c;
  evt_t             evt;

  function automatic logic [REG_W-1:0] pick(input int unsigned i,
                                            input logic [REG_W-1:0] mem,
                                            input logic [REG_W-1:0] a,
                                            input logic [REG_W-1:0] b,
                                            input logic [REG_W-1:0] c);
    case (i)
      IDX_A:   return a;
      IDX_B:   return b;
      IDX_C:   return c;
      IDX_D:   return FIXED_D;
      default: return mem;
    endcase
  endfunction

  assign host_wr  = bus_cs_i && bus_we_i;
  assign host_rd  = bus_cs_i && !bus_we_i;
  assign idx_ld   = host_wr && !bus_addr_i;
  assign dat_wr   = host_wr && bus_addr_i;
  assign cur_ctl  = is_ctl_idx(32'(idx_q));
  assign cur_time = is_time_idx(32'(idx_q));
  assign cal_ctl  = is_ctl_idx(32'(cal_idx_i));

  assign st_hwe  = dat_wr && !cur_ctl;
  assign st_awe  = cal_wr_i && !cal_ctl;
  assign wr_a    = dat_wr && (32'(idx_q) == IDX_A);
  assign wr_b    = dat_wr && (32'(idx_q) == IDX_B);
  assign wr_time = dat_wr && cur_time;
  assign rd_c    = host_rd && bus_addr_i && (32'(idx_q) == IDX_C);
  assign evt     = '{per: per_set_i, alm: alm_set_i, upd: upd_set_i};

  rtc_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (idx_ld),
    .d_i   (bus_wdata_i[IDX_W-1:0]),
    .q_o   (idx_q)
  );

  rtc_byte_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(REG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .hwe_i  (st_hwe),
    .hidx_i (idx_q),
    .hdat_i (bus_wdata_i),
    .awe_i  (st_awe),
    .aidx_i (cal_idx_i),
    .adat_i (cal_data_i),
    .ra0_i  (idx_q),
    .rd0_o  (st_rd0),
    .ra1_i  (cal_rd_idx_i),
    .rd1_o  (st_rd1)
  );

  rtc_ctrl_regs u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_clr_i   (soft_clr_i),
    .wr_a_i       (wr_a),
    .wr_b_i       (wr_b),
    .wr_time_i    (wr_time),
    .rd_c_i       (rd_c),
    .wdata_i      (bus_wdata_i),
    .evt_i        (evt),
    .uip_set_i    (uip_set_i),
    .reg_a_o      (ctl_a),
    .reg_b_o      (ctl_b),
    .reg_c_o      (ctl_c),
    .cal_load_o   (cal_load_o),
    .cal_render_o (cal_render_o),
    .irq_o        (irq_o)
  );

  assign bus_rdata_o   = bus_addr_i ? pick(32'(idx_q), st_rd0, ctl_a, ctl_b, ctl_c)
                                    : IDX_RDVAL;
  assign cal_rd_data_o = pick(32'(cal_rd_idx_i), st_rd1, ctl_a, ctl_b, ctl_c);
  assign hold_o        = ctl_b[B_HOLD];
  assign bin_mode_o    = ctl_b[B_BIN];
  assign h24_o         = ctl_b[B_H24];

endmodule

// File: rtl/rtc_host_regs_chk.sv
module rtc_host_regs_chk #(
  parameter int unsigned IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr_i,
  input logic             bus_cs_i,
  input logic             bus_we_i,
  input logic             bus_addr_i,
  input logic [7:0]       bus_wdata_i,
  input logic [7:0]       bus_rdata_o,
  input logic             upd_set_i,
  input logic             uip_set_i,
  input logic             cal_load_o,
  input logic             cal_render_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       ctl_a,
  input logic [7:0]       ctl_b,
  input logic [7:0]       ctl_c
);

  logic dwr, drd;
  assign dwr = bus_cs_i && bus_we_i && bus_addr_i;
  assign drd = bus_cs_i && !bus_we_i && bus_addr_i;

  AST_IDX_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_i && !bus_we_i && !bus_addr_i) |-> (bus_rdata_o == 8'hFF)); // R1

  AST_D_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && idx_q == IDX_W'(13)) |-> (bus_rdata_o == 8'h80)); // R3

  AST_UIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == IDX_W'(10) && !uip_set_i && !upd_set_i)
    |=> (ctl_a[7] == $past(ctl_a[7]))); // R4

  AST_HOLD_MASKS_UEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == IDX_W'(11) && bus_wdata_i[7])
    |=> (!ctl_b[4] && !ctl_a[7])); // R5

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load_o |-> $past(dwr)); // R6

  AST_RENDER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_render_o |-> $past(dwr && idx_q == IDX_W'(11) && !bus_wdata_i[7])); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ctl_b[6:4] != 3'b000)); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && idx_q == IDX_W'(12)) |=> (!irq_o && ctl_c == 8'h00)); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_i |=> (!irq_o && !ctl_b[6] && !ctl_b[5] && !ctl_b[3])); // R12

endmodule

bind rtc_host_regs rtc_host_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_clr_i   (soft_clr_i),
  .bus_cs_i     (bus_cs_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .upd_set_i    (upd_set_i),
  .uip_set_i    (uip_set_i),
  .cal_load_o   (cal_load_o),
  .cal_render_o (cal_render_o),
  .irq_o        (irq_o),
  .idx_q        (idx_q),
  .ctl_a        (ctl_a),
  .ctl_b        (ctl_b),
  .ctl_c        (ctl_c)
);

// File: tb/rtc_host_regs_tb.sv
module rtc_host_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int IW         = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          soft_clr_i, bus_cs_i, bus_we_i, bus_addr_i;
  logic [7:0]    bus_wdata_i, bus_rdata_o;
  logic          per_set_i, alm_set_i, upd_set_i, uip_set_i, cal_wr_i;
  logic [IW-1:0] cal_idx_i, cal_rd_idx_i;
  logic [7:0]    cal_data_i, cal_rd_data_o;
  logic          cal_load_o, cal_render_o, hold_o, bin_mode_o, h24_o, irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_host_regs #(.DEPTH(DEPTH)) u_dut (.*);

  int n_chk  = 0;
  int n_fail = 0;

  // staged stimulus
  logic          s_cs, s_we, s_addr, s_per, s_alm, s_upd, s_uip, s_cwr, s_soft;
  logic [7:0]    s_wd, s_cdat;
  logic [IW-1:0] s_cidx, s_crd;

  // reference model
  logic [7:0]    m_mem [DEPTH];
  logic [IW-1:0] m_idx;
  logic [7:0]    m_a, m_b, m_c;
  logic [2:0]    m_pend;   // {per, alm, upd}
  logic          m_load, m_rend;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic is_time(input int i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9;
  endfunction

  function automatic logic [7:0] m_pick(input int i);
    case (i)
      10: return m_a;
      11: return m_b;
      12: return m_c;
      13: return 8'h80;
      default: return m_mem[i];
    endcase
  endfunction

  task automatic idle();
    s_cs = 0; s_we = 0; s_addr = 0; s_wd = 0;
    s_per = 0; s_alm = 0; s_upd = 0; s_uip = 0;
    s_cwr = 0; s_cidx = 0; s_cdat = 0; s_soft = 0; s_crd = 0;
  endtask

  task automatic model_step();
    logic [7:0] na, nb, nc;
    logic [2:0] ev;
    logic       dwr, nload, nrend, hwr_store;
    int         ci;
    na = m_a; nb = m_b; nc = m_c; nload = 0; nrend = 0;
    dwr = s_cs && s_we && s_addr;
    hwr_store = dwr && !(m_idx >= 10 && m_idx <= 13);
    ev = {s_per, s_alm, s_upd} | m_pend;
    if (dwr && m_idx == 10) na[6:0] = s_wd[6:0];
    if (s_uip && !m_b[7]) na[7] = 1'b1;
    if (s_upd || (dwr && m_idx == 11 && s_wd[7])) na[7] = 1'b0;
    if (dwr && m_idx == 11) begin
      nb = s_wd;
      if (s_wd[7]) nb[4] = 1'b0;
      nload = !s_wd[7] && m_b[7];
      nrend = !s_wd[7] && (s_wd[2:1] != m_b[2:1]);
    end
    if (dwr && is_time(int'(m_idx)) && !m_b[7]) nload = 1'b1;
    ci = int'(s_cidx);
    if (s_cwr && !(ci >= 10 && ci <= 13) && !(hwr_store && s_cidx == m_idx))
      m_mem[ci] = s_cdat;
    if (hwr_store) m_mem[m_idx] = s_wd;
    if (s_cs && s_we && !s_addr) m_idx = s_wd[6:0];
    if (s_soft) begin
      nb[6] = 0; nb[5] = 0; nb[3] = 0; nc = 0; m_pend = 0;
    end else if (s_cs && !s_we && s_addr && m_idx == 12 && !(s_cs && s_we)) begin
      nc = 0; m_pend = ev;
    end else begin
      m_pend = 0;
      nc[6] = nc[6] | ev[2];
      nc[5] = nc[5] | ev[1];
      nc[4] = nc[4] | ev[0];
      if ((ev[2] && m_b[6]) || (ev[1] && m_b[5]) || (ev[0] && m_b[4])) nc[7] = 1'b1;
    end
    m_a = na; m_b = nb; m_c = nc; m_load = nload; m_rend = nrend;
  endtask

  // one clock: apply at falling edge, check reads, model at rising edge, check registered outputs
  task automatic tick();
    string tg;
    @(negedge clk);
    soft_clr_i = s_soft; bus_cs_i = s_cs; bus_we_i = s_we; bus_addr_i = s_addr;
    bus_wdata_i = s_wd; per_set_i = s_per; alm_set_i = s_alm; upd_set_i = s_upd;
    uip_set_i = s_uip; cal_wr_i = s_cwr; cal_idx_i = s_cidx; cal_data_i = s_cdat;
    cal_rd_idx_i = s_crd;
    #1;
    if (s_cs && !s_we) begin
      if (!s_addr) tg = "R1";
      else case (int'(m_idx))
        10: tg = "R4";
        11: tg = "R5";
        12: tg = "R9";
        13: tg = "R3";
        default: tg = "R2";
      endcase
      chk(bus_rdata_o, s_addr ? m_pick(int'(m_idx)) : 8'hFF, tg);
    end
    chk(cal_rd_data_o, m_pick(int'(s_crd)), "R2 calendar read");
    @(posedge clk);
    model_step();
    #1;
    chk({7'd0, cal_load_o},   {7'd0, m_load}, "R6 load strobe");
    chk({7'd0, cal_render_o}, {7'd0, m_rend}, "R7 render strobe");
    chk({7'd0, irq_o},        {7'd0, m_c[7]}, "R8 irq");
    chk({7'd0, hold_o},       {7'd0, m_b[7]}, "R5 hold");
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    idle(); s_cs = 1; s_we = 1; s_addr = a; s_wd = d; tick();
  endtask

  task automatic rd_sel(input logic [6:0] i);
    wr(0, {1'b0, i});
    idle(); s_cs = 1; s_we = 0; s_addr = 1; tick();
  endtask

  // returns read data sampled in the access cycle of the following tick
  task automatic peek(input logic [6:0] i, output logic [7:0] v);
    wr(0, {1'b0, i});
    idle(); s_cs = 1; s_addr = 1;
    @(negedge clk);
    bus_cs_i = 1; bus_we_i = 0; bus_addr_i = 1; soft_clr_i = 0; cal_wr_i = 0;
    per_set_i = 0; alm_set_i = 0; upd_set_i = 0; uip_set_i = 0;
    #1 v = bus_rdata_o;
    @(posedge clk);
    model_step();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_0123));
    idle();
    soft_clr_i = 0; bus_cs_i = 0; bus_we_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
    per_set_i = 0; alm_set_i = 0; upd_set_i = 0; uip_set_i = 0; cal_wr_i = 0;
    cal_idx_i = 0; cal_data_i = 0; cal_rd_idx_i = 0;
    rst_n = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    m_idx = 0; m_a = 8'h26; m_b = 8'h02; m_c = 0; m_pend = 0; m_load = 0; m_rend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset values
    chk({7'd0, irq_o}, 8'h00, "R11 irq after reset");
    peek(7'd10, v); chk(v, 8'h26, "R11 A reset");
    peek(7'd11, v); chk(v, 8'h02, "R11 B reset");
    peek(7'd12, v); chk(v, 8'h00, "R11 C reset");
    peek(7'd13, v); chk(v, 8'h80, "R11 D reset");

    // R1 index uses low seven bits
    wr(0, 8'h85); wr(1, 8'h5A);
    peek(7'd5, v); chk(v, 8'h5A, "R1 index low bits");
    idle(); s_cs = 1; s_addr = 0; tick();

    // R3 writes to C and D ignored
    wr(0, 8'd12); wr(1, 8'hFF); peek(7'd12, v); chk(v, 8'h00, "R3 C write ignored");
    wr(0, 8'd13); wr(1, 8'h00); peek(7'd13, v); chk(v, 8'h80, "R3 D write ignored");

    // R4 update-in-progress bit
    wr(0, 8'd10); wr(1, 8'hFF); peek(7'd10, v); chk(v, 8'h7F, "R4 A write keeps bit7");
    idle(); s_uip = 1; tick();
    wr(0, 8'd10); wr(1, 8'h26); peek(7'd10, v); chk(v, 8'hA6, "R4 uip kept on write");
    idle(); s_upd = 1; tick();
    peek(7'd10, v); chk(v, 8'h26, "R4 update end clears uip");
    rd_sel(7'd12);

    // R5 set mode masks update enable and clears uip
    idle(); s_uip = 1; tick();
    wr(0, 8'd11); wr(1, 8'h92);
    chk({7'd0, hold_o}, 8'h01, "R5 hold high");
    peek(7'd11, v); chk(v, 8'h82, "R5 UEN forced low");
    peek(7'd10, v); chk(v[7:0], 8'h26, "R5 uip cleared");

    // R6 load strobe rules
    wr(0, 8'd0); wr(1, 8'h11); chk({7'd0, cal_load_o}, 8'h00, "R6 no load in hold");
    wr(0, 8'd11); wr(1, 8'h02); chk({7'd0, cal_load_o}, 8'h01, "R6 load on hold exit");
    wr(0, 8'd2); wr(1, 8'h30); chk({7'd0, cal_load_o}, 8'h01, "R6 load on time write");
    wr(0, 8'd1); wr(1, 8'h30); chk({7'd0, cal_load_o}, 8'h00, "R6 no load on alarm write");

    // R7 render strobe
    wr(0, 8'd11); wr(1, 8'h06); chk({7'd0, cal_render_o}, 8'h01, "R7 render on format change");
    wr(1, 8'h06); chk({7'd0, cal_render_o}, 8'h00, "R7 no render when same");
    wr(1, 8'h02); chk({7'd0, cal_render_o}, 8'h01, "R7 render on bin clear");

    // R8 + R9 + R10 flag during read-clear
    wr(1, 8'h42);
    idle(); s_alm = 1; tick();
    chk({7'd0, irq_o}, 8'h00, "R8 alarm without enable");
    wr(0, 8'd12);
    idle(); s_cs = 1; s_addr = 1; s_per = 1; tick();
    chk({7'd0, irq_o}, 8'h00, "R9 irq low after read");
    idle(); tick();
    chk({7'd0, irq_o}, 8'h01, "R10 held flag raises irq");
    peek(7'd12, v); chk(v, 8'hC0, "R10 held flag in C");
    chk({7'd0, irq_o}, 8'h00, "R9 cleared again");

    // R12 soft clear
    wr(0, 8'd11); wr(1, 8'h7A);
    idle(); s_per = 1; tick();
    idle(); s_soft = 1; tick();
    chk({7'd0, irq_o}, 8'h00, "R12 irq low");
    peek(7'd11, v); chk(v, 8'h12, "R12 enables cleared");

    // R2 calendar write collides with host write
    wr(0, 8'd40);
    idle(); s_cs = 1; s_we = 1; s_addr = 1; s_wd = 8'hAA; s_cwr = 1; s_cidx = 7'd40; s_cdat = 8'h55; tick();
    peek(7'd40, v); chk(v, 8'hAA, "R2 host wins collision");
    idle(); s_cwr = 1; s_cidx = 7'd4; s_cdat = 8'h23; tick();
    peek(7'd4, v); chk(v, 8'h23, "R2 calendar write-back");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int op;
      idle();
      op = int'($urandom_range(0, 99));
      s_cs = (op < 85);
      if (op < 25) begin
        s_we = 1; s_addr = 0;
        s_wd = ($urandom_range(0, 9) < 8) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      end else if (op < 55) begin
        s_we = 1; s_addr = 1; s_wd = 8'($urandom);
      end else begin
        s_we = 0; s_addr = ($urandom_range(0, 9) != 0);
      end
      s_per  = ($urandom_range(0, 7) == 0);
      s_alm  = ($urandom_range(0, 7) == 0);
      s_upd  = ($urandom_range(0, 7) == 0);
      s_uip  = ($urandom_range(0, 7) == 0);
      s_cwr  = ($urandom_range(0, 7) == 0);
      s_cidx = IW'($urandom_range(0, 15));
      s_cdat = 8'($urandom);
      s_soft = ($urandom_range(0, 63) == 0);
      s_crd  = IW'($urandom_range(0, 15));
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule